// File: doc/BRIEF.md
# Receive Interrupt Source Arbiter

This block sits beside the receive FIFO of a serial receiver and decides when the receiver asks the processor for service and what it reports as the cause. It takes a level that says a character is waiting, single-cycle pulses for three error-class events (parity error, overrun, end of frame), a mode selection, a frame-status-FIFO enable, an error-reset command strobe and a vector-read strobe.

Error-class events are held pending until software issues an error reset. While pending, they can stop the receive FIFO from advancing and pause DMA, depending on whether the frame-status FIFO is in use. The 2-bit source code is captured when the vector is read. That code ranks a waiting character above a pending error, so the captured code can say "character" even in the mode where only errors can raise the request. The FIFO storage and the DMA engine are outside the block. It drives only their control levels.

Top module: `rx_irq_arbiter`

## Requirements
- R1: After reset, `irq_o` is 0, `vec_o` is 2'b00, `fifo_lock_o` is 0 and `dma_en_o` is 1.
- R2: Mode 2'b01 (every character): while `char_avail_i` is 1, `irq_o` is 1 in the same cycle, without any register in the path.
- R3: Mode 2'b10 (errors only): `char_avail_i` alone never raises `irq_o`.
- R4: A pulse on `parity_err_i`, `overrun_i` or `eof_i` sets a pending error from the next cycle on. The pending error holds until a cycle with `err_reset_i` high and no new event, and it clears in the cycle after that. If an event and `err_reset_i` arrive together, the error stays pending.
- R5: In modes 2'b01 and 2'b10, a pending error drives `irq_o` to 1.
- R6: On a cycle with `vec_rd_i` high, `vec_o` loads a code that takes effect in the next cycle. The code is 2'b01 if the mode is 2'b01 or 2'b10 and `char_avail_i` is 1. Otherwise it is 2'b10 if the mode is 2'b01 or 2'b10 and an error is pending. Otherwise it is 2'b00. Without `vec_rd_i`, `vec_o` holds its value.
- R7: A waiting character outranks a pending error in the captured code, also in mode 2'b10.
- R8: With `frame_stat_en_i` at 0, any error event sets `fifo_lock_o` to 1 and `dma_en_o` to 0 from the next cycle on, until the error reset clears them in the cycle after it is sampled.
- R9: With `frame_stat_en_i` at 1, `fifo_lock_o` never rises. An overrun clears `dma_en_o`, while parity and end-of-frame events leave `dma_en_o` at 1. The error reset restores `dma_en_o`.
- R10: Modes 2'b00 and 2'b11 (off) keep `irq_o` at 0. Error events are still latched while the mode is off, and they raise the request once an active mode is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| char_avail_i | input | 1 | Level: at least one character is waiting |
| parity_err_i | input | 1 | Pulse: parity error event |
| overrun_i | input | 1 | Pulse: overrun event |
| eof_i | input | 1 | Pulse: end-of-frame event |
| rx_mode_i | input | 2 | 00 off, 01 every character, 10 errors only, 11 off |
| frame_stat_en_i | input | 1 | Frame-status FIFO in use |
| err_reset_i | input | 1 | Pulse: error reset command |
| vec_rd_i | input | 1 | Pulse: capture the source code |
| irq_o | output | 1 | Receive interrupt request |
| vec_o | output | 2 | Captured source code (00 none, 01 character, 10 error) |
| fifo_lock_o | output | 1 | Hold the receive FIFO |
| dma_en_o | output | 1 | Receive DMA allowed |

## Verification
The assertions assume that every input has a known value from the first clock after reset and changes only between edges. They also assume that events and commands are qualified by the clock, so that one pulse means one event. The bench drives all inputs on the falling edge and holds each event or command high for exactly one clock. It keeps the mode and the frame-status enable steady around every pulse whose effect it checks. Simultaneous events and commands are produced deliberately, so that the event-wins rule and the character-over-error ranking are both exercised.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;
  parameter int VEC_W  = 2;
  parameter int MODE_W = 2;

  typedef logic [VEC_W-1:0] vec_t;

  typedef enum logic [MODE_W-1:0] {
    RXM_OFF   = 2'b00,
    RXM_ALL   = 2'b01,
    RXM_SPEC  = 2'b10,
    RXM_OFF_B = 2'b11
  } rx_mode_e;

  localparam vec_t VEC_NONE = 2'b00;
  localparam vec_t VEC_CHAR = 2'b01;
  localparam vec_t VEC_ERR  = 2'b10;
endpackage

// File: rtl/rx_err_track.sv
module rx_err_track #(
  parameter int N_EVT   = 3,
  parameter int OVR_IDX = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             err_reset_i,
  input  logic             frame_stat_en_i,
  output logic             pend_o,
  output logic             lock_o,
  output logic             dma_en_o
);
  logic any_evt;
  logic pend_q, pend_d;
  logic lock_q, lock_d;
  logic dma_off_q, dma_off_d;

  always_comb begin
    any_evt   = |evt_i;
    pend_d    = pend_q;
    lock_d    = lock_q;
    dma_off_d = dma_off_q;
    if (err_reset_i) begin
      pend_d    = 1'b0;
      lock_d    = 1'b0;
      dma_off_d = 1'b0;
    end
    if (any_evt) pend_d = 1'b1;
    if (any_evt && !frame_stat_en_i) begin
      lock_d    = 1'b1;
      dma_off_d = 1'b1;
    end
    if (evt_i[OVR_IDX]) dma_off_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      lock_q    <= 1'b0;
      dma_off_q <= 1'b0;
    end else begin
      pend_q    <= pend_d;
      lock_q    <= lock_d;
      dma_off_q <= dma_off_d;
    end
  end

  assign pend_o   = pend_q;
  assign lock_o   = lock_q;
  assign dma_en_o = !dma_off_q;

  // R4: pending error survives until an error reset
  p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o && !err_reset_i |=> pend_o);
  // R4: reset without a new event clears the pending error
  p_pend_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_reset_i && !(|evt_i) |=> !pend_o);
  // R9: lock never rises while the frame-status FIFO is in use
  p_no_lock_fs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stat_en_i && !lock_o |=> !lock_o);
  // R9: an overrun always pauses DMA
  p_ovr_dma_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i[OVR_IDX] |=> !dma_en_o);
  // R8: lock set by an error in direct mode
  p_lock_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) && !frame_stat_en_i |=> lock_o && !dma_en_o);
endmodule

// File: rtl/rx_irq_req.sv
module rx_irq_req
  import rx_irq_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              char_avail_i,
  input  logic              pend_i,
  output logic              src_on_o,
  output logic              irq_o
);
  rx_mode_e mode;

  always_comb begin
    mode     = rx_mode_e'(mode_i);
    src_on_o = (mode == RXM_ALL) || (mode == RXM_SPEC);
    irq_o    = (src_on_o && pend_i) || ((mode == RXM_ALL) && char_avail_i);
  end
endmodule

// File: rtl/rx_vec_cap.sv
module rx_vec_cap
  import rx_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_i,
  input  logic src_on_i,
  input  logic char_avail_i,
  input  logic pend_i,
  output vec_t vec_o
);
  vec_t vec_q, vec_d, vec_sel;

  always_comb begin
    if (src_on_i && char_avail_i) vec_sel = VEC_CHAR;
    else if (src_on_i && pend_i)  vec_sel = VEC_ERR;
    else                          vec_sel = VEC_NONE;
    vec_d = rd_i ? vec_sel : vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= VEC_NONE;
    else        vec_q <= vec_d;
  end

  assign vec_o = vec_q;

  // R6: code held between reads
  p_vec_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(vec_o));
  // R7: waiting character outranks a pending error
  p_vec_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i && src_on_i && char_avail_i |=> vec_o == VEC_CHAR);
endmodule

// File: rtl/rx_irq_arbiter.sv
module rx_irq_arbiter
  import rx_irq_pkg::*;
#(
  parameter int N_EVT   = 3,
  parameter int OVR_IDX = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_avail_i,
  input  logic              parity_err_i,
  input  logic              overrun_i,
  input  logic              eof_i,
  input  logic [MODE_W-1:0] rx_mode_i,
  input  logic              frame_stat_en_i,
  input  logic              err_reset_i,
  input  logic              vec_rd_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              fifo_lock_o,
  output logic              dma_en_o
);
  logic [N_EVT-1:0] evt;
  logic             pend;
  logic             src_on;

  assign evt = {eof_i, overrun_i, parity_err_i};

  rx_err_track #(.N_EVT(N_EVT), .OVR_IDX(OVR_IDX)) u_err (
    .clk             (clk),
    .rst_n           (rst_n),
    .evt_i           (evt),
    .err_reset_i     (err_reset_i),
    .frame_stat_en_i (frame_stat_en_i),
    .pend_o          (pend),
    .lock_o          (fifo_lock_o),
    .dma_en_o        (dma_en_o)
  );

  rx_irq_req u_req (
    .mode_i       (rx_mode_i),
    .char_avail_i (char_avail_i),
    .pend_i       (pend),
    .src_on_o     (src_on),
    .irq_o        (irq_o)
  );

  rx_vec_cap u_vec (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_i         (vec_rd_i),
    .src_on_i     (src_on),
    .char_avail_i (char_avail_i),
    .pend_i       (pend),
    .vec_o        (vec_o)
  );

  // R3: errors-only mode stays quiet without a pending error
  p_spec_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode_i == RXM_SPEC) && !pend |-> !irq_o);
  // R10: off modes never request
  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode_i == RXM_OFF) || (rx_mode_i == RXM_OFF_B) |-> !irq_o);
  // R5: a pending error requests in an active mode
  p_pend_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend && src_on |-> irq_o);
endmodule

// File: tb/tb_rx_irq_arbiter.sv
module tb_rx_irq_arbiter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       char_avail_i, parity_err_i, overrun_i, eof_i;
  logic [1:0] rx_mode_i;
  logic       frame_stat_en_i, err_reset_i, vec_rd_i;
  logic       irq_o;
  logic [1:0] vec_o;
  logic       fifo_lock_o, dma_en_o;
  int         n_chk = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;

  rx_irq_arbiter dut (
    .clk(clk), .rst_n(rst_n), .char_avail_i(char_avail_i),
    .parity_err_i(parity_err_i), .overrun_i(overrun_i), .eof_i(eof_i),
    .rx_mode_i(rx_mode_i), .frame_stat_en_i(frame_stat_en_i),
    .err_reset_i(err_reset_i), .vec_rd_i(vec_rd_i), .irq_o(irq_o),
    .vec_o(vec_o), .fifo_lock_o(fifo_lock_o), .dma_en_o(dma_en_o)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive a one-cycle pulse from a falling edge; returns at the next falling edge
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: parity_err_i = 1'b1;
      1: overrun_i    = 1'b1;
      2: eof_i        = 1'b1;
      3: err_reset_i  = 1'b1;
      default: vec_rd_i = 1'b1;
    endcase
    @(negedge clk);
    parity_err_i = 1'b0; overrun_i = 1'b0; eof_i = 1'b0;
    err_reset_i  = 1'b0; vec_rd_i  = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 irq", {3'b0, irq_o}, 4'h0);
    chk("R1 vec", {2'b0, vec_o}, 4'h0);
    chk("R1 lock", {3'b0, fifo_lock_o}, 4'h0);
    chk("R1 dma", {3'b0, dma_en_o}, 4'h1);
  endtask

  task automatic t_every_char;
    @(negedge clk); rx_mode_i = 2'b01; char_avail_i = 1'b1; #1;
    chk("R2 char raises irq", {3'b0, irq_o}, 4'h1);
    char_avail_i = 1'b0; #1;
    chk("R2 irq drops", {3'b0, irq_o}, 4'h0);
  endtask

  task automatic t_spec_only;
    @(negedge clk); rx_mode_i = 2'b10; char_avail_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 char alone quiet", {3'b0, irq_o}, 4'h0);
    end
    pulse(4);
    chk("R6 char code in spec mode", {2'b0, vec_o}, 4'h1);
    char_avail_i = 1'b0;
  endtask

  task automatic t_latch_lock;
    @(negedge clk); frame_stat_en_i = 1'b0; rx_mode_i = 2'b10;
    pulse(0);
    chk("R5 irq after parity", {3'b0, irq_o}, 4'h1);
    chk("R8 lock", {3'b0, fifo_lock_o}, 4'h1);
    chk("R8 dma paused", {3'b0, dma_en_o}, 4'h0);
    repeat (4) @(negedge clk);
    chk("R4 still pending", {3'b0, irq_o}, 4'h1);
    pulse(3);
    chk("R4 cleared", {3'b0, irq_o}, 4'h0);
    chk("R8 unlocked", {3'b0, fifo_lock_o}, 4'h0);
    chk("R8 dma resumed", {3'b0, dma_en_o}, 4'h1);
  endtask

  task automatic t_vector;
    @(negedge clk); rx_mode_i = 2'b10; frame_stat_en_i = 1'b0;
    pulse(2);
    pulse(4);
    chk("R6 error code", {2'b0, vec_o}, 4'h2);
    @(negedge clk); char_avail_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 held without read", {2'b0, vec_o}, 4'h2);
    pulse(4);
    chk("R7 char outranks error", {2'b0, vec_o}, 4'h1);
    @(negedge clk); char_avail_i = 1'b0;
    pulse(3);
    pulse(4);
    chk("R6 none after reset", {2'b0, vec_o}, 4'h0);
  endtask

  task automatic t_simul;
    @(negedge clk); rx_mode_i = 2'b10; frame_stat_en_i = 1'b0;
    // character and error in the same cycle, read taken in that cycle too
    char_avail_i = 1'b1; eof_i = 1'b1; vec_rd_i = 1'b1;
    @(negedge clk); eof_i = 1'b0; vec_rd_i = 1'b0; char_avail_i = 1'b0;
    chk("R7 same-cycle char wins", {2'b0, vec_o}, 4'h1);
    chk("R5 error requests", {3'b0, irq_o}, 4'h1);
    @(negedge clk); err_reset_i = 1'b1; overrun_i = 1'b1;
    @(negedge clk); err_reset_i = 1'b0; overrun_i = 1'b0;
    chk("R4 event beats reset", {3'b0, irq_o}, 4'h1);
    pulse(3);
    chk("R4 cleared after", {3'b0, irq_o}, 4'h0);
  endtask

  task automatic t_frame_stat;
    @(negedge clk); rx_mode_i = 2'b01; frame_stat_en_i = 1'b1;
    pulse(1);
    chk("R9 no lock on overrun", {3'b0, fifo_lock_o}, 4'h0);
    chk("R9 overrun pauses dma", {3'b0, dma_en_o}, 4'h0);
    pulse(3);
    chk("R9 dma restored", {3'b0, dma_en_o}, 4'h1);
    pulse(0);
    chk("R9 parity keeps dma", {3'b0, dma_en_o}, 4'h1);
    chk("R9 parity no lock", {3'b0, fifo_lock_o}, 4'h0);
    chk("R5 parity requests", {3'b0, irq_o}, 4'h1);
    pulse(2);
    chk("R9 eof keeps dma", {3'b0, dma_en_o}, 4'h1);
    pulse(3);
    @(negedge clk); frame_stat_en_i = 1'b0;
  endtask

  task automatic t_off;
    @(negedge clk); rx_mode_i = 2'b00; char_avail_i = 1'b1;
    pulse(0);
    chk("R10 off quiet", {3'b0, irq_o}, 4'h0);
    pulse(4);
    chk("R10 off code none", {2'b0, vec_o}, 4'h0);
    @(negedge clk); rx_mode_i = 2'b11; #1;
    chk("R10 mode 11 quiet", {3'b0, irq_o}, 4'h0);
    char_avail_i = 1'b0; rx_mode_i = 2'b10; #1;
    chk("R10 latched error raises", {3'b0, irq_o}, 4'h1);
    pulse(3);
  endtask

  initial begin
    rst_n = 1'b0; char_avail_i = 1'b0; parity_err_i = 1'b0; overrun_i = 1'b0;
    eof_i = 1'b0; rx_mode_i = 2'b00; frame_stat_en_i = 1'b0;
    err_reset_i = 1'b0; vec_rd_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_every_char();
    t_spec_only();
    t_latch_lock();
    t_vector();
    t_simul();
    t_frame_stat();
    t_off();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule